// File: doc/BRIEF.md
# Segmented Pointer Protection Checker

This block sits between an address-generation stage and the memory system of a processor whose pointers name a segment rather than a flat address. Each request picks one of four base pointers, adds a 16-bit displacement to that pointer's half-word offset, and states the access type and the ring the code is running in. One cycle later the block returns either a clean result or a single fault code. The result carries the 29-bit flat byte address and a copy of the effective pointer that is safe to store back to memory.

Privilege can only be weakened. The ring used for a check combines the executing ring and the pointer's own ring so that the less privileged of the two wins. That same ring is written into the pointer handed back for storing, so a pointer made by user code keeps its user ring even after privileged code copies it. The block holds a per-segment descriptor table with read, write and execute rights for each ring, and a page-present map. Both are loaded through plain write strobes. The four base pointers are loaded through two strobes: one for the general pointer and one for the procedure call/return path.

Requests and results use valid/ready. `req_ready` is high whenever the result register is empty, or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken.

Top module: `segptr_guard`

## Requirements
- R1: Pointer layout is bit 31 fault, bits 30:29 ring, bit 28 byte select, bits 27:16 segment, bits 15:0 half-word offset. `rsp_addr` equals {segment, offset, byte select} of the effective pointer (29 bits).
- R2: The effective offset is the base offset plus `req_disp` modulo 65536. Segment, byte select and fault bit come unchanged from the base pointer, so there is never a carry into the segment.
- R3: The effective ring is the bitwise OR of `req_ring` and the base pointer's ring (0 strongest, 3 weakest). `rsp_ptr` is the effective pointer with its ring field set to that effective ring.
- R4: `req_base` selects 0 = code, 1 = static, 2 = frame, 3 = general. Only `gen_ld_en` loads the general pointer. Only `call_en` loads the other three, from `call_code_ptr`, `call_static_ptr` and `call_frame_ptr`.
- R5: Descriptor permission bit 3*ring+0 is read, 3*ring+1 is write and 3*ring+2 is execute. `req_acc` is 0 read, 1 write, 2 execute; code 3 is never permitted. A request whose type is not permitted for the effective ring gives fault code 3.
- R6: A base pointer with its fault bit set gives fault code 1.
- R7: A segment whose descriptor is not present gives fault code 2. Only segments below `DESC_DEPTH` are backed; any segment at or above it is never present, and descriptor or page writes aimed there are dropped.
- R8: The page map holds one bit per 1024-half-word page. It is indexed by segment and offset bits 15:10. An access to a clear page bit gives fault code 4.
- R9: Only one fault is reported, by priority 1 > 2 > 3 > 4. Code 0 means no fault.
- R10: A request accepted on a clock edge has its result valid after that edge. The result stays stable while `rsp_ready` is low.
- R11: Descriptor, page and base-pointer writes made in the same cycle as an accepted request take effect from the next request onward.
- R12: After reset the result register is empty, all base pointers are zero, and every descriptor and page bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_base | input | 2 | Base pointer select |
| req_disp | input | 16 | Half-word displacement |
| req_acc | input | 2 | Access type |
| req_ring | input | 2 | Executing ring |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_fault | output | 3 | Fault code, 0 when clean |
| rsp_addr | output | 29 | Flat byte address |
| rsp_ptr | output | 32 | Ring-weakened effective pointer |
| gen_ld_en | input | 1 | Load general pointer |
| gen_ld_ptr | input | 32 | Value for general pointer |
| call_en | input | 1 | Call/return strobe |
| call_code_ptr | input | 32 | New code pointer |
| call_static_ptr | input | 32 | New static pointer |
| call_frame_ptr | input | 32 | New frame pointer |
| dsc_we | input | 1 | Descriptor write |
| dsc_seg | input | 12 | Descriptor segment |
| dsc_present | input | 1 | Segment present flag |
| dsc_perm | input | 12 | Permission bits per ring |
| pg_we | input | 1 | Page map write |
| pg_seg | input | 12 | Page map segment |
| pg_idx | input | 6 | Page index in segment |
| pg_present | input | 1 | Page present flag |

## Verification
The assertions assume that the consumer's `rsp_ready` is a plain level. They also assume that pointers arriving on the load ports may carry any ring and any fault bit, so the ring checks cover weakened values and do not rely on clean pointers. They make no demand that `req_valid` stays asserted until it is taken. The stimulus therefore drives random valid and ready patterns, including dropping a request before it is accepted. The random traffic chooses segments from a small set that mixes present, absent and out-of-range entries. This lets every fault class and every priority overlap occur many times within a short run.

// File: rtl/segptr_pkg.sv
package segptr_pkg;
  localparam int RING_W = 2;
  localparam int SEG_W  = 12;
  localparam int OFF_W  = 16;
  localparam int NRING  = 1 << RING_W;
  localparam int PERM_W = 3 * NRING;
  localparam int PTR_W  = 1 + RING_W + 1 + SEG_W + OFF_W;
  localparam int FLAT_W = SEG_W + OFF_W + 1;
  localparam int NBASE  = 4;
  localparam int SEL_W  = $clog2(NBASE);

  // Field order is behaviour: the flat address is a rotate of the low bits.
  typedef struct packed {
    logic              flt;
    logic [RING_W-1:0] ring;
    logic              bsel;
    logic [SEG_W-1:0]  seg;
    logic [OFF_W-1:0]  off;
  } segptr_t;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_BAD = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_PTR  = 3'd1,
    FLT_SEG  = 3'd2,
    FLT_ACC  = 3'd3,
    FLT_PAGE = 3'd4
  } fault_e;

  localparam logic [SEL_W-1:0] SEL_GEN = SEL_W'(NBASE - 1);
endpackage

// File: rtl/segptr_basefile.sv
module segptr_basefile
  import segptr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        gen_ld_en,
  input  logic [PTR_W-1:0]            gen_ld_ptr,
  input  logic                        call_en,
  input  logic [(NBASE-1)*PTR_W-1:0]  call_ptrs,
  input  logic [SEL_W-1:0]            rd_sel,
  output segptr_t                     rd_ptr
);
  logic [NBASE*PTR_W-1:0] bank;

  for (genvar g = 0; g < NBASE; g++) begin : g_base
    logic [PTR_W-1:0] r;
    if (g == int'(SEL_GEN)) begin : g_general
      always_ff @(posedge clk) begin
        if (!rst_n)         r <= '0;
        else if (gen_ld_en) r <= gen_ld_ptr;
      end
    end else begin : g_callset
      always_ff @(posedge clk) begin
        if (!rst_n)       r <= '0;
        else if (call_en) r <= call_ptrs[g*PTR_W +: PTR_W];
      end
    end
    assign bank[g*PTR_W +: PTR_W] = r;
  end

  assign rd_ptr = segptr_t'(bank[rd_sel*PTR_W +: PTR_W]);
endmodule

// File: rtl/segptr_tables.sv
module segptr_tables
  import segptr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PG_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dsc_we,
  input  logic [SEG_W-1:0]   dsc_seg,
  input  logic               dsc_present,
  input  logic [PERM_W-1:0]  dsc_perm,
  input  logic               pg_we,
  input  logic [SEG_W-1:0]   pg_seg,
  input  logic [PG_W-1:0]    pg_idx,
  input  logic               pg_present,
  input  logic [SEG_W-1:0]   lk_seg,
  input  logic [PG_W-1:0]    lk_pg,
  output logic               lk_present,
  output logic [PERM_W-1:0]  lk_perm,
  output logic               lk_page
);
  localparam int NPG   = 1 << PG_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  pres_q;
  logic [PERM_W-1:0] perm_q [DEPTH];
  logic [NPG-1:0]    page_q [DEPTH];

  function automatic logic backed(input logic [SEG_W-1:0] s);
    return 32'(s) < 32'(DEPTH);
  endfunction

  wire dsc_hit = dsc_we && backed(dsc_seg);
  wire pg_hit  = pg_we && backed(pg_seg);
  wire [IDX_W-1:0] dsc_i = dsc_seg[IDX_W-1:0];
  wire [IDX_W-1:0] pg_i  = pg_seg[IDX_W-1:0];
  wire [IDX_W-1:0] lk_i  = lk_seg[IDX_W-1:0];
  wire             lk_ok = backed(lk_seg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        perm_q[i] <= '0;
        page_q[i] <= '0;
      end
    end else begin
      if (dsc_hit) begin
        pres_q[dsc_i] <= dsc_present;
        perm_q[dsc_i] <= dsc_perm;
      end
      if (pg_hit) page_q[pg_i][pg_idx] <= pg_present;
    end
  end

  assign lk_present = lk_ok && pres_q[lk_i];
  assign lk_perm    = perm_q[lk_i];
  assign lk_page    = page_q[lk_i][lk_pg];
endmodule

// File: rtl/segptr_judge.sv
module segptr_judge
  import segptr_pkg::*;
#(
  parameter int PG_W = 6
) (
  input  segptr_t             base_ptr,
  input  logic [OFF_W-1:0]    disp,
  input  acc_e                acc,
  input  logic [RING_W-1:0]   cur_ring,
  output logic [SEG_W-1:0]    lk_seg,
  output logic [PG_W-1:0]     lk_pg,
  input  logic                seg_present,
  input  logic [PERM_W-1:0]   seg_perm,
  input  logic                page_present,
  output fault_e              fault,
  output logic [FLAT_W-1:0]   flat_addr,
  output segptr_t             store_ptr
);
  segptr_t    eff;
  logic [2:0] ring_rights;
  logic       allowed;

  always_comb begin
    eff      = base_ptr;
    eff.off  = base_ptr.off + disp;
    eff.ring = base_ptr.ring | cur_ring;
  end

  assign lk_seg    = eff.seg;
  assign lk_pg     = eff.off[OFF_W-1 -: PG_W];
  assign store_ptr = eff;
  assign flat_addr = {eff.seg, eff.off, eff.bsel};

  always_comb begin
    ring_rights = '0;
    for (int r = 0; r < NRING; r++)
      if (eff.ring == RING_W'(r)) ring_rights = seg_perm[3*r +: 3];
  end

  always_comb begin
    unique case (acc)
      ACC_RD:  allowed = ring_rights[0];
      ACC_WR:  allowed = ring_rights[1];
      ACC_EX:  allowed = ring_rights[2];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (eff.flt)          fault = FLT_PTR;
    else if (!seg_present) fault = FLT_SEG;
    else if (!allowed)     fault = FLT_ACC;
    else if (!page_present) fault = FLT_PAGE;
    else                   fault = FLT_NONE;
  end
endmodule

// File: rtl/segptr_guard.sv
module segptr_guard
  import segptr_pkg::*;
#(
  parameter int DESC_DEPTH = 64,
  parameter int PG_W       = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEL_W-1:0]     req_base,
  input  logic [OFF_W-1:0]     req_disp,
  input  logic [1:0]           req_acc,
  input  logic [RING_W-1:0]    req_ring,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [2:0]           rsp_fault,
  output logic [FLAT_W-1:0]    rsp_addr,
  output logic [PTR_W-1:0]     rsp_ptr,
  input  logic                 gen_ld_en,
  input  logic [PTR_W-1:0]     gen_ld_ptr,
  input  logic                 call_en,
  input  logic [PTR_W-1:0]     call_code_ptr,
  input  logic [PTR_W-1:0]     call_static_ptr,
  input  logic [PTR_W-1:0]     call_frame_ptr,
  input  logic                 dsc_we,
  input  logic [SEG_W-1:0]     dsc_seg,
  input  logic                 dsc_present,
  input  logic [PERM_W-1:0]    dsc_perm,
  input  logic                 pg_we,
  input  logic [SEG_W-1:0]     pg_seg,
  input  logic [PG_W-1:0]      pg_idx,
  input  logic                 pg_present
);
  segptr_t           base_sel;
  logic [SEG_W-1:0]  lk_seg;
  logic [PG_W-1:0]   lk_pg;
  logic              lk_present, lk_page;
  logic [PERM_W-1:0] lk_perm;
  fault_e            fault_d;
  logic [FLAT_W-1:0] flat_d;
  segptr_t           store_d;

  logic              vld_q;
  logic [2:0]        fault_q;
  logic [FLAT_W-1:0] addr_q;
  logic [PTR_W-1:0]  ptr_q;

  wire take = req_valid && req_ready;

  segptr_basefile u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_ld_en (gen_ld_en),
    .gen_ld_ptr(gen_ld_ptr),
    .call_en   (call_en),
    .call_ptrs ({call_frame_ptr, call_static_ptr, call_code_ptr}),
    .rd_sel    (req_base),
    .rd_ptr    (base_sel)
  );

  segptr_tables #(.DEPTH(DESC_DEPTH), .PG_W(PG_W)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .dsc_we     (dsc_we),
    .dsc_seg    (dsc_seg),
    .dsc_present(dsc_present),
    .dsc_perm   (dsc_perm),
    .pg_we      (pg_we),
    .pg_seg     (pg_seg),
    .pg_idx     (pg_idx),
    .pg_present (pg_present),
    .lk_seg     (lk_seg),
    .lk_pg      (lk_pg),
    .lk_present (lk_present),
    .lk_perm    (lk_perm),
    .lk_page    (lk_page)
  );

  segptr_judge #(.PG_W(PG_W)) u_judge (
    .base_ptr    (base_sel),
    .disp        (req_disp),
    .acc         (acc_e'(req_acc)),
    .cur_ring    (req_ring),
    .lk_seg      (lk_seg),
    .lk_pg       (lk_pg),
    .seg_present (lk_present),
    .seg_perm    (lk_perm),
    .page_present(lk_page),
    .fault       (fault_d),
    .flat_addr   (flat_d),
    .store_ptr   (store_d)
  );

  // One result slot; it may refill in the cycle it drains.
  assign req_ready = !vld_q || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      fault_q <= '0;
      addr_q  <= '0;
      ptr_q   <= '0;
    end else if (take) begin
      vld_q   <= 1'b1;
      fault_q <= fault_d;
      addr_q  <= flat_d;
      ptr_q   <= store_d;
    end else if (rsp_ready) begin
      vld_q   <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_fault = fault_q;
  assign rsp_addr  = addr_q;
  assign rsp_ptr   = ptr_q;
endmodule

// File: rtl/segptr_guard_chk.sv
module segptr_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_ring,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [2:0]  rsp_fault,
  input logic [28:0] rsp_addr,
  input logic [31:0] rsp_ptr
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_addr) && $stable(rsp_ptr));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_empty_takes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  assert_ring_weak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (($past(req_ring) & ~rsp_ptr[30:29]) == 2'b00));

  assert_flat_rotate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr == {rsp_ptr[27:0], rsp_ptr[28]});

  assert_ptr_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ptr[31] |-> rsp_fault == 3'd1);

  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd4);
endmodule

bind segptr_guard segptr_guard_chk u_chk (.*);

// File: tb/sim_segptr_guard.sv
`timescale 1ns/1ps
module sim_segptr_guard;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, rsp_valid, rsp_ready;
  logic [1:0] req_base, req_acc, req_ring;
  logic [15:0] req_disp;
  logic [2:0] rsp_fault;
  logic [28:0] rsp_addr;
  logic [31:0] rsp_ptr, gen_ld_ptr, call_code_ptr, call_static_ptr, call_frame_ptr;
  logic gen_ld_en, call_en, dsc_we, dsc_present, pg_we, pg_present;
  logic [11:0] dsc_seg, dsc_perm, pg_seg;
  logic [5:0] pg_idx;

  segptr_guard u0 (.*);

  int checks = 0, errs = 0;
  string tag = "R12";
  bit done = 0;

  // behavioural reference state
  bit          m_valid;
  logic [2:0]  m_fault;
  logic [28:0] m_addr;
  logic [31:0] m_ptr;
  logic [31:0] m_base [4];
  bit          m_pres [DEPTH];
  logic [11:0] m_perm [DEPTH];
  logic [63:0] m_page [DEPTH];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic predict();
    logic [31:0] b;
    logic [15:0] off;
    logic [1:0]  r;
    int seg;
    b   = m_base[req_base];
    seg = int'(b[27:16]);
    off = b[15:0] + req_disp;
    r   = b[30:29] | req_ring;
    m_ptr  = {b[31], r, b[28], b[27:16], off};
    m_addr = {b[27:16], off, b[28]};
    if (b[31]) m_fault = 3'd1;
    else if (seg >= DEPTH || !m_pres[seg]) m_fault = 3'd2;
    else if (req_acc == 2'd3 || !m_perm[seg][3*int'(r) + int'(req_acc)]) m_fault = 3'd3;
    else if (!m_page[seg][off[15:10]]) m_fault = 3'd4;
    else m_fault = 3'd0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0;
      for (int i = 0; i < 4; i++) m_base[i] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        m_pres[i] = 0; m_perm[i] = '0; m_page[i] = '0;
      end
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        predict();
        m_valid = 1;
      end else if (rsp_ready) m_valid = 0;
      if (gen_ld_en) m_base[3] = gen_ld_ptr;
      if (call_en) begin
        m_base[0] = call_code_ptr; m_base[1] = call_static_ptr; m_base[2] = call_frame_ptr;
      end
      if (dsc_we && int'(dsc_seg) < DEPTH) begin
        m_pres[dsc_seg] = dsc_present; m_perm[dsc_seg] = dsc_perm;
      end
      if (pg_we && int'(pg_seg) < DEPTH) m_page[pg_seg][pg_idx] = pg_present;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("rsp_valid", 32'(rsp_valid), 32'(m_valid));
      chk("req_ready", 32'(req_ready), 32'(!m_valid || rsp_ready));
      if (m_valid) begin
        chk("rsp_fault", 32'(rsp_fault), 32'(m_fault));
        chk("rsp_addr", 32'(rsp_addr), 32'(m_addr));
        chk("rsp_ptr", rsp_ptr, m_ptr);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [1:0] sel, input logic [15:0] d, input logic [1:0] a, input logic [1:0] r);
    bit ok;
    req_valid = 1; req_base = sel; req_disp = d; req_acc = a; req_ring = r;
    do begin
      @(negedge clk); ok = req_ready;
      @(posedge clk); #1;
    end while (!ok);
    req_valid = 0;
  endtask

  task automatic wr_desc(input logic [11:0] s, input logic p, input logic [11:0] perm);
    dsc_we = 1; dsc_seg = s; dsc_present = p; dsc_perm = perm;
    tick();
    dsc_we = 0;
  endtask

  task automatic wr_page(input logic [11:0] s, input logic [5:0] i, input logic v);
    pg_we = 1; pg_seg = s; pg_idx = i; pg_present = v;
    tick();
    pg_we = 0;
  endtask

  function automatic logic [11:0] pick_seg();
    case ($urandom % 6)
      0, 1, 2, 3: return 12'(4 + $urandom % 4);
      4:          return 12'(100 + $urandom % 3000);
      default:    return 12'($urandom % 64);
    endcase
  endfunction

  function automatic logic [31:0] rnd_ptr();
    return {1'($urandom % 16 == 0), 2'($urandom), 1'($urandom), pick_seg(), 16'($urandom)};
  endfunction

  initial begin
    rst_n = 0; req_valid = 0; req_base = 0; req_disp = 0; req_acc = 0; req_ring = 0;
    rsp_ready = 1; gen_ld_en = 0; gen_ld_ptr = 0; call_en = 0;
    call_code_ptr = 0; call_static_ptr = 0; call_frame_ptr = 0;
    dsc_we = 0; dsc_seg = 0; dsc_present = 0; dsc_perm = 0;
    pg_we = 0; pg_seg = 0; pg_idx = 0; pg_present = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R12: empty after reset, zero base hits an absent segment
    @(negedge clk);
    chk("reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("reset req_ready", 32'(req_ready), 32'd1);
    tick();
    send(2'd0, 16'h0000, 2'd0, 2'd0);
    tick();
    @(negedge clk);
    chk("empty table fault", 32'(rsp_fault), 32'd2);
    tick();

    // R4: base registers via the two load paths
    tag = "R4";
    call_en = 1;
    call_code_ptr   = {1'b0, 2'b00, 1'b0, 12'd5, 16'h0100};
    call_static_ptr = {1'b0, 2'b11, 1'b1, 12'd6, 16'h0010};
    call_frame_ptr  = {1'b0, 2'b00, 1'b0, 12'd5, 16'hFFF0};
    tick(); call_en = 0;
    gen_ld_en = 1; gen_ld_ptr = {1'b1, 2'b00, 1'b0, 12'd5, 16'h0000};
    tick(); gen_ld_en = 0;
    wr_desc(12'd5, 1, 12'hFFF);
    wr_desc(12'd6, 1, 12'h207);
    wr_desc(12'd7, 0, 12'hFFF);
    for (int i = 0; i < 64; i++) wr_page(12'd5, 6'(i), i != 3);
    for (int i = 0; i < 64; i++) wr_page(12'd6, 6'(i), 1'b1);
    send(2'd0, 16'h0002, 2'd0, 2'd0);
    send(2'd2, 16'h0001, 2'd1, 2'd0);
    tag = "R1";
    send(2'd1, 16'h0004, 2'd0, 2'd0);
    tag = "R2";
    send(2'd2, 16'h0020, 2'd0, 2'd0);
    send(2'd0, 16'hFF00, 2'd2, 2'd1);
    tag = "R3";
    send(2'd1, 16'h0000, 2'd0, 2'd0);
    send(2'd0, 16'h0000, 2'd2, 2'd2);
    tag = "R5";
    send(2'd1, 16'h0000, 2'd1, 2'd0);
    send(2'd1, 16'h0000, 2'd2, 2'd0);
    send(2'd0, 16'h0000, 2'd3, 2'd0);
    tag = "R6";
    send(2'd3, 16'h0000, 2'd0, 2'd0);
    tag = "R7";
    gen_ld_en = 1; gen_ld_ptr = {1'b0, 2'b00, 1'b0, 12'd7, 16'h0000}; tick(); gen_ld_en = 0;
    send(2'd3, 16'h0000, 2'd0, 2'd0);
    gen_ld_en = 1; gen_ld_ptr = {1'b0, 2'b00, 1'b0, 12'd100, 16'h0000}; tick(); gen_ld_en = 0;
    wr_desc(12'd100, 1, 12'hFFF);
    send(2'd3, 16'h0000, 2'd0, 2'd0);
    tag = "R8";
    send(2'd0, 16'h0B00, 2'd0, 2'd0);
    tag = "R9";
    gen_ld_en = 1; gen_ld_ptr = {1'b1, 2'b11, 1'b0, 12'd7, 16'h0000}; tick(); gen_ld_en = 0;
    send(2'd3, 16'h0000, 2'd1, 2'd0);
    gen_ld_en = 1; gen_ld_ptr = {1'b0, 2'b11, 1'b0, 12'd7, 16'h0C00}; tick(); gen_ld_en = 0;
    send(2'd3, 16'h0000, 2'd1, 2'd0);
    wr_page(12'd6, 6'd0, 1'b0);
    send(2'd1, 16'h0000, 2'd1, 2'd0);
    send(2'd1, 16'h0000, 2'd0, 2'd0);

    // R10: stall with a second request waiting
    tag = "R10";
    tick();
    rsp_ready = 0;
    send(2'd0, 16'h0010, 2'd0, 2'd0);
    req_valid = 1; req_base = 2'd2; req_disp = 16'h0030; req_acc = 0; req_ring = 0;
    repeat (4) tick();
    rsp_ready = 1;
    tick();
    req_valid = 0;
    tick();

    // R11: descriptor write alongside an accepted request
    tag = "R11";
    req_valid = 1; req_base = 2'd0; req_disp = 16'h0002; req_acc = 2'd1; req_ring = 0;
    dsc_we = 1; dsc_seg = 12'd5; dsc_present = 1; dsc_perm = 12'h000;
    tick();
    dsc_we = 0;
    tick();
    req_valid = 0;
    tick();
    wr_desc(12'd5, 1, 12'hFFF);

    tag = "mix";
    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 4) != 0;
      req_base = 2'($urandom); req_disp = 16'($urandom);
      req_acc = 2'($urandom); req_ring = 2'($urandom);
      rsp_ready = ($urandom % 3) != 0;
      gen_ld_en = ($urandom % 8) == 0; gen_ld_ptr = rnd_ptr();
      call_en = ($urandom % 16) == 0;
      call_code_ptr = rnd_ptr(); call_static_ptr = rnd_ptr(); call_frame_ptr = rnd_ptr();
      dsc_we = ($urandom % 8) == 0; dsc_seg = pick_seg();
      dsc_present = ($urandom % 4) != 0; dsc_perm = 12'($urandom);
      pg_we = ($urandom % 2) == 0; pg_seg = pick_seg(); pg_idx = 6'($urandom);
      pg_present = ($urandom % 4) != 0;
      tick();
    end
    req_valid = 0; gen_ld_en = 0; call_en = 0; dsc_we = 0; pg_we = 0; rsp_ready = 1;
    repeat (3) tick();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog %s actual=running expected=finished", tag);
      done = 1;
      summary();
      $finish;
    end
  end
endmodule